// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit logical address into a physical address by walking a two-level page table that sits in memory. A client, typically translation logic that has just missed in its lookaside cache, raises a request carrying the logical address, the root address of the outer table and the number of outer entries that are in use. The walker first checks the outer index against that count. It then fetches one outer entry and, from the frame that entry names, one inner entry. It finishes with either a physical address or a fault that says which step failed.

Pages are 1 KB. The 22-bit page number splits into a 12-bit outer index (address bits 31:20) and a 10-bit inner index (bits 19:10). Memory is reached through a single read port. The walker holds a request and its address until a response returns, which may take any number of cycles. At most one read is outstanding.

Top module: `pt_walk`

## Requirements
- R1: After reset, busy_o, done_o, fault_o and mem_req_o are all low.
- R2: A request that is sampled while idle raises busy_o from the next cycle. busy_o stays high through the cycle of the done or fault pulse and is low in the cycle after it.
- R3: If the outer index (vaddr[31:20]) is greater than or equal to table_len_i, the walker faults with fault_code_o = 1 and issues no memory read.
- R4: The first read address is table_root_i + 4 × vaddr[31:20].
- R5: If the outer entry has bit 0 (valid) clear, the walker faults with fault_code_o = 2 after exactly one read.
- R6: The second read address is {outer_entry[31:10], 10'b0} + 4 × vaddr[19:10].
- R7: If the inner entry has bit 0 clear, the walker faults with fault_code_o = 3 after exactly two reads.
- R8: On success, done_o pulses and paddr_o = {inner_entry[31:10], vaddr[9:0]}. fault_code_o is 0 during that pulse.
- R9: mem_req_o stays high with a stable mem_addr_o until mem_rvalid_i is seen, whatever the response latency.
- R10: A request raised while busy_o is high is ignored and does not alter the walk in progress.
- R11: done_o and fault_o are never high together, and each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Start a walk (sampled while idle) |
| req_vaddr_i | input | 32 | Logical address to translate |
| table_root_i | input | 32 | Byte address of the outer table |
| table_len_i | input | 13 | Number of valid outer entries (0 to 4096) |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle pulse: translation succeeded |
| fault_o | output | 1 | One-cycle pulse: translation failed |
| fault_code_o | output | 2 | 0 none, 1 length, 2 outer invalid, 3 inner invalid |
| paddr_o | output | 32 | Physical address, valid with done_o |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory read byte address |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 32 | Read response data |

## Verification
The bench builds the walker with its default parameters: a 32-bit address, a 10-bit offset, a 12-bit outer index and 32-bit entries. With these values the full 4096-entry length range can be reached, including a length of 0, the index one below the length, the index equal to it and the largest outer index. A hashed memory model gives random response latencies from 0 to 4 cycles and mostly valid entries. Directed cases plant an invalid entry at exactly the outer or the inner address that a walk will fetch.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_RD_OUTER,
    ST_RD_INNER,
    ST_DONE,
    ST_FAULT
  } walk_state_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_LEN   = 2'd1,
    FLT_OUTER = 2'd2,
    FLT_INNER = 2'd3
  } fault_e;

endpackage

// File: rtl/pt_va_split.sv
module pt_va_split #(
  parameter int VA_W    = 32,
  parameter int OFF_W   = 10,
  parameter int OUTER_W = 12,
  localparam int INNER_W = VA_W - OFF_W - OUTER_W
) (
  input  logic [VA_W-1:0]    vaddr_i,
  output logic [OUTER_W-1:0] outer_idx_o,
  output logic [INNER_W-1:0] inner_idx_o,
  output logic [OFF_W-1:0]   offset_o
);
  assign outer_idx_o = vaddr_i[VA_W-1 -: OUTER_W];
  assign inner_idx_o = vaddr_i[OFF_W +: INNER_W];
  assign offset_o    = vaddr_i[OFF_W-1:0];
endmodule

// File: rtl/pt_slot_addr.sv
module pt_slot_addr #(
  parameter int AW          = 32,
  parameter int IDX_W       = 12,
  parameter int ENTRY_BYTES = 4,
  localparam int SH = $clog2(ENTRY_BYTES)
) (
  input  logic [AW-1:0]    base_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [AW-1:0]    addr_o
);
  assign addr_o = base_i + {{(AW-IDX_W-SH){1'b0}}, idx_i, {SH{1'b0}}};
endmodule

// File: rtl/pt_entry_dec.sv
module pt_entry_dec #(
  parameter int PTE_W = 32,
  parameter int OFF_W = 10
) (
  input  logic [PTE_W-1:0] pte_i,
  output logic             valid_o,
  output logic [PTE_W-1:0] frame_base_o
);
  logic unused_bits;
  assign unused_bits  = ^pte_i[OFF_W-1:1];
  assign valid_o      = pte_i[0];
  assign frame_base_o = {pte_i[PTE_W-1:OFF_W], {OFF_W{1'b0}}};
endmodule

// File: rtl/pt_walk.sv
module pt_walk
  import pt_walk_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int OFF_W   = 10,
  parameter int OUTER_W = 12,
  parameter int PTE_W   = 32,
  localparam int INNER_W     = VA_W - OFF_W - OUTER_W,
  localparam int LEN_W       = OUTER_W + 1,
  localparam int AW          = PTE_W,
  localparam int ENTRY_BYTES = PTE_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [VA_W-1:0]   req_vaddr_i,
  input  logic [AW-1:0]     table_root_i,
  input  logic [LEN_W-1:0]  table_len_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fault_o,
  output logic [1:0]        fault_code_o,
  output logic [PTE_W-1:0]  paddr_o,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [PTE_W-1:0]  mem_rdata_i
);

  walk_state_e state_q, state_d;
  fault_e      fault_q, fault_d;
  logic [VA_W-1:0]  vaddr_q;
  logic [AW-1:0]    root_q;
  logic [LEN_W-1:0] len_q;
  logic [AW-1:0]    inner_base_q, inner_base_d;
  logic [PTE_W-1:0] paddr_q, paddr_d;

  logic [OUTER_W-1:0] outer_idx;
  logic [INNER_W-1:0] inner_idx;
  logic [OFF_W-1:0]   offset;
  logic [AW-1:0]      outer_addr, inner_addr;
  logic               pte_valid;
  logic [PTE_W-1:0]   frame_base;
  logic               out_of_range;

  pt_va_split #(.VA_W(VA_W), .OFF_W(OFF_W), .OUTER_W(OUTER_W)) u_split (
    .vaddr_i     (vaddr_q),
    .outer_idx_o (outer_idx),
    .inner_idx_o (inner_idx),
    .offset_o    (offset)
  );

  pt_slot_addr #(.AW(AW), .IDX_W(OUTER_W), .ENTRY_BYTES(ENTRY_BYTES)) u_outer_addr (
    .base_i (root_q),
    .idx_i  (outer_idx),
    .addr_o (outer_addr)
  );

  pt_slot_addr #(.AW(AW), .IDX_W(INNER_W), .ENTRY_BYTES(ENTRY_BYTES)) u_inner_addr (
    .base_i (inner_base_q),
    .idx_i  (inner_idx),
    .addr_o (inner_addr)
  );

  pt_entry_dec #(.PTE_W(PTE_W), .OFF_W(OFF_W)) u_dec (
    .pte_i        (mem_rdata_i),
    .valid_o      (pte_valid),
    .frame_base_o (frame_base)
  );

  assign out_of_range = {1'b0, outer_idx} >= len_q;

  always_comb begin
    state_d      = state_q;
    fault_d      = fault_q;
    inner_base_d = inner_base_q;
    paddr_d      = paddr_q;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        state_d = ST_CHECK;
        fault_d = FLT_NONE;
      end
      ST_CHECK: begin
        if (out_of_range) begin
          state_d = ST_FAULT;
          fault_d = FLT_LEN;
        end else begin
          state_d = ST_RD_OUTER;
        end
      end
      ST_RD_OUTER: if (mem_rvalid_i) begin
        if (!pte_valid) begin
          state_d = ST_FAULT;
          fault_d = FLT_OUTER;
        end else begin
          state_d      = ST_RD_INNER;
          inner_base_d = frame_base;
        end
      end
      ST_RD_INNER: if (mem_rvalid_i) begin
        if (!pte_valid) begin
          state_d = ST_FAULT;
          fault_d = FLT_INNER;
        end else begin
          state_d = ST_DONE;
          paddr_d = frame_base | {{(PTE_W-OFF_W){1'b0}}, offset};
        end
      end
      ST_DONE:  state_d = ST_IDLE;
      ST_FAULT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      fault_q      <= FLT_NONE;
      vaddr_q      <= '0;
      root_q       <= '0;
      len_q        <= '0;
      inner_base_q <= '0;
      paddr_q      <= '0;
    end else begin
      state_q      <= state_d;
      fault_q      <= fault_d;
      inner_base_q <= inner_base_d;
      paddr_q      <= paddr_d;
      if (state_q == ST_IDLE && req_valid_i) begin
        vaddr_q <= req_vaddr_i;
        root_q  <= table_root_i;
        len_q   <= table_len_i;
      end
    end
  end

  assign busy_o       = state_q != ST_IDLE;
  assign done_o       = state_q == ST_DONE;
  assign fault_o      = state_q == ST_FAULT;
  assign fault_code_o = fault_q;
  assign paddr_o      = paddr_q;
  assign mem_req_o    = (state_q == ST_RD_OUTER) || (state_q == ST_RD_INNER);
  assign mem_addr_o   = (state_q == ST_RD_INNER) ? inner_addr : outer_addr;

  // R3
  len_no_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CHECK && out_of_range) |=> (fault_o && !mem_req_o && fault_code_o == FLT_LEN));

  // R5
  outer_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD_OUTER && mem_rvalid_i && !pte_valid) |=> (fault_o && fault_code_o == FLT_OUTER));

  // R9
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R9
  mem_in_walk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  // R2
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && !fault_o) |=> busy_o);

  // R10
  ignore_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && req_valid_i) |=> $stable(vaddr_q));

  // R11
  pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o));

  // R11
  pulse_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fault_o) |=> (!done_o && !fault_o && !busy_o));

endmodule

// File: tb/pt_walk_bench.sv
module pt_walk_bench;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic [31:0] root;
  logic [12:0] len;
  logic        busy, done, fault;
  logic [1:0]  fcode;
  logic [31:0] paddr;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;

  pt_walk u_pt_walk (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .req_valid_i  (req_valid),
    .req_vaddr_i  (req_vaddr),
    .table_root_i (root),
    .table_len_i  (len),
    .busy_o       (busy),
    .done_o       (done),
    .fault_o      (fault),
    .fault_code_o (fcode),
    .paddr_o      (paddr),
    .mem_req_o    (mem_req),
    .mem_addr_o   (mem_addr),
    .mem_rvalid_i (mem_rvalid),
    .mem_rdata_i  (mem_rdata)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // memory model
  logic        bad_en   = 1'b0;
  logic [31:0] bad_addr = '0;
  int          lat_cnt, lat_tgt, reads;
  logic [31:0] cur_addr;
  logic [31:0] log_q [4];

  function automatic logic [31:0] pte_of(logic [31:0] a);
    logic [31:0] h;
    h = (a * 32'h9E3779B1) ^ 32'h5A5A1234;
    h = h ^ (h >> 15);
    if (bad_en && a == bad_addr) return h & ~32'd1;
    return (h[7:4] == 4'd0) ? (h & ~32'd1) : (h | 32'd1);
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
      lat_cnt    <= 0;
      lat_tgt    <= 1;
      reads      <= 0;
    end else if (mem_rvalid) begin
      mem_rvalid      <= 1'b0;
      lat_cnt         <= 0;
      lat_tgt         <= int'($urandom_range(0, 4));
      log_q[reads % 4] <= cur_addr;
      reads           <= reads + 1;
    end else if (mem_req) begin
      if (lat_cnt >= lat_tgt) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= pte_of(mem_addr);
        cur_addr   <= mem_addr;
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  task automatic predict(input logic [31:0] va, input logic [31:0] rt, input logic [12:0] ln,
                         output int code, output logic [31:0] pa, output int nrd,
                         output logic [31:0] a0, output logic [31:0] a1);
    logic [31:0] e0, e1;
    a0 = rt + {18'd0, va[31:20], 2'b00};
    e0 = pte_of(a0);
    a1 = {e0[31:10], 10'd0} + {20'd0, va[19:10], 2'b00};
    e1 = pte_of(a1);
    pa = {e1[31:10], va[9:0]};
    if ({1'b0, va[31:20]} >= ln) begin code = 1; nrd = 0; end
    else if (!e0[0])             begin code = 2; nrd = 1; end
    else if (!e1[0])             begin code = 3; nrd = 2; end
    else                         begin code = 0; nrd = 2; end
  endtask

  task automatic run_walk(logic [31:0] va, logic [31:0] rt, logic [12:0] ln, bit poke, string tag);
    int code, nrd, r0, n;
    logic [31:0] pa, a0, a1;
    predict(va, rt, ln, code, pa, nrd, a0, a1);
    r0 = reads;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; root = rt; len = ln;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b1, {"R2 busy after accept ", tag}, 32'(busy), 1);
    if (poke) begin
      // R10: second request while busy must not disturb the walk
      req_valid = 1'b1; req_vaddr = ~va; root = rt ^ 32'h0000_1000; len = 13'd4096;
      @(negedge clk);
      req_valid = 1'b0;
    end
    n = 0;
    while (!(done || fault) && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(busy === 1'b1, {"R2 busy in pulse ", tag}, 32'(busy), 1);
    chk(!(done && fault), {"R11 exclusive ", tag}, {done, fault}, 0);
    if (code == 0) begin
      chk(done === 1'b1, {"R8 done ", tag}, 32'(done), 1);
      chk(fcode === 2'd0, {"R8 code ", tag}, 32'(fcode), 0);
      chk(paddr === pa, {"R8 paddr ", tag}, paddr, pa);
    end else begin
      chk(fault === 1'b1, {"R3 R5 R7 fault ", tag}, 32'(fault), 1);
      chk(fcode === 2'(code), {"R3 R5 R7 code ", tag}, 32'(fcode), code);
    end
    @(negedge clk);
    chk(!busy && !done && !fault, {"R11 R10 one-cycle end ", tag}, {busy, done, fault}, 0);
    chk(reads - r0 == nrd, {"R3 R5 R7 read count ", tag}, reads - r0, nrd);
    if (nrd >= 1) chk(log_q[r0 % 4] === a0, {"R4 outer addr ", tag}, log_q[r0 % 4], a0);
    if (nrd >= 2) chk(log_q[(r0 + 1) % 4] === a1, {"R6 inner addr ", tag}, log_q[(r0 + 1) % 4], a1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rt, a0, e0, va;
    void'($urandom(32'd4242));
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; root = '0; len = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fault && !mem_req, "R1 reset outputs", {busy, done, fault, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_req, "R1 idle after release", {busy, mem_req}, 0);

    // R3 length boundaries
    run_walk(32'h0000_1234, 32'h0010_0000, 13'd0,    0, "len0");
    run_walk(32'h0040_0000, 32'h0010_0000, 13'd4,    0, "idx_eq_len");
    run_walk(32'h0030_0000, 32'h0010_0000, 13'd4,    0, "idx_len_minus1");
    run_walk(32'hFFF0_03FF, 32'h0020_0000, 13'd4096, 0, "max_idx");
    run_walk(32'hFFF0_03FF, 32'h0020_0000, 13'd4095, 0, "max_idx_oor");

    // R5 invalid outer entry
    va = 32'h0123_4567; rt = 32'h0008_0000;
    bad_en = 1'b1; bad_addr = rt + {18'd0, va[31:20], 2'b00};
    run_walk(va, rt, 13'd4096, 0, "outer_bad");

    // R7 invalid inner entry: choose a root with a valid outer entry
    va = 32'h089A_BCDE; rt = 32'h0004_0000;
    bad_en = 1'b0;
    for (int i = 0; i < 64; i++) begin
      a0 = rt + {18'd0, va[31:20], 2'b00};
      e0 = pte_of(a0);
      if (e0[0]) break;
      rt = rt + 32'h100;
    end
    bad_en = 1'b1; bad_addr = {e0[31:10], 10'd0} + {20'd0, va[19:10], 2'b00};
    run_walk(va, rt, 13'd4096, 0, "inner_bad");
    bad_en = 1'b0;

    // R10 requests while busy
    run_walk(32'h1111_2222, 32'h0030_0000, 13'd4096, 1, "poke_ok");
    run_walk(32'hF000_0000, 32'h0030_0000, 13'd16,   1, "poke_len");

    // random walks, R9 variable latency from the memory model
    for (int k = 0; k < 120; k++) begin
      logic [12:0] ln;
      ln = ($urandom_range(0, 3) == 0) ? 13'($urandom_range(0, 4096)) : 13'd4096;
      run_walk($urandom, {$urandom_range(0, 32'hFFFF), 16'h0} | 32'($urandom_range(0, 255) * 4),
               ln, $urandom_range(0, 7) == 0, "random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule